// File: doc/BRIEF.md
# Early Channel-Ready Wait-State Decoder

This block sits beside a Micro Channel slave and decides, within a few clocks of the start of a bus cycle, whether that cycle must be stretched. It looks at the memory/IO status line, the two status strobes and the low part of the address. When an I/O cycle lands in a configured address window, it pulls the channel-ready line low in time for the host to insert wait states. A slow backend, such as an emulated peripheral that needs several hundred nanoseconds, then has time to finish its work.

The stretch is requested only after a positive window match, never speculatively. The decision is taken once per bus cycle, from status and partial address alone, and only inside a deadline counted in clocks after the cycle-start indication. The line is released one clock after the backend reports completion, at once when the cycle ends or is abandoned, or after a maximum stretch. A forced release also sets a sticky error flag. Full address capture and data transfer belong to other blocks.

Top module: `chrdy_early_stretch`

## Requirements
- R1: After reset, `chrdy_drive` and `timeout_err` are 0. A new reset clears a previously set `timeout_err`.
- R2: The status decode is: read when `s0`=1 and `s1`=0, write when `s0`=0 and `s1`=1, and no valid status otherwise. The cycle after `cyc_start` is decide cycle 1. If decide cycle k (k ≤ DEADLINE_CYC) is the first with valid status and that status matches, `chrdy_drive` is 1 from cycle k+1 onward.
- R3: A cycle with `m_io`=1 (memory) is never stretched. Only `m_io`=0 (I/O) cycles can match.
- R4: An address matches when `((addr_lo ^ cfg_base) & cfg_mask) == 0`. A mask bit of 0 makes that address bit a don't-care. Addresses outside the window are never stretched.
- R5: Read cycles are stretched only when `cfg_rd_en`=1, and write cycles only when `cfg_wr_en`=1.
- R6: If valid status first appears after decide cycle DEADLINE_CYC, the cycle is not stretched.
- R7: When `be_done` is 1 in a stretch cycle, `chrdy_drive` is 0 from the next cycle. A `be_done` before the stretch begins has no effect.
- R8: `chrdy_drive` is 0 in any cycle where `cyc_end` is 1, and it stays 0 until a later `cyc_start` produces a new match.
- R9: After MAX_STRETCH consecutive stretch cycles without `be_done` or `cyc_end`, `chrdy_drive` drops and `timeout_err` becomes 1 at the same edge. `timeout_err` then stays 1 until reset.
- R10: The decision is made once per bus cycle. Address or status changes after the decide cycle cannot start a stretch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start | input | 1 | One-clock pulse at the start of a bus cycle |
| cyc_end | input | 1 | Bus cycle finished or abandoned |
| m_io | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| s0 | input | 1 | Status strobe 0 |
| s1 | input | 1 | Status strobe 1 |
| addr_lo | input | ADDR_W | Low address bits |
| cfg_base | input | ADDR_W | Window base address |
| cfg_mask | input | ADDR_W | Window compare mask, 1 = compare this bit |
| cfg_rd_en | input | 1 | Allow stretching of read cycles |
| cfg_wr_en | input | 1 | Allow stretching of write cycles |
| be_done | input | 1 | Backend has completed the access |
| chrdy_drive | output | 1 | 1 = pull the channel-ready line low |
| timeout_err | output | 1 | Sticky flag for a forced release |

## Verification
A matched request shows on `chrdy_drive` one clock after the decide cycle that saw valid status. A release by `be_done` takes one clock, and a timeout release takes MAX_STRETCH stretch cycles, with the error flag rising at the same edge. The `cyc_end` release is combinational within the same cycle. The bench drives every input one time unit after a rising edge and samples `chrdy_drive` before changing the inputs for that cycle, so each sample reflects the registers loaded at the previous edge. The `cyc_end` check is taken one unit after the strobe is raised, inside the same cycle. The expected first high cycle, high-cycle count and error flag come from a bench function written from the requirements.

// File: rtl/chrdy_pkg.sv
package chrdy_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_DECIDE  = 2'd1,
    ST_STRETCH = 2'd2,
    ST_HOLD    = 2'd3
  } seq_state_e;

endpackage

// File: rtl/chrdy_window_match.sv
module chrdy_window_match #(
  parameter int ADDR_W = 8
) (
  input  logic              m_io,
  input  logic              s0,
  input  logic              s1,
  input  logic [ADDR_W-1:0] addr_lo,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_mask,
  input  logic              cfg_rd_en,
  input  logic              cfg_wr_en,
  output logic              status_valid,
  output logic              hit
);

  logic [ADDR_W-1:0] bit_ok;
  logic              addr_ok;
  logic              is_read;
  logic              dir_ok;

  for (genvar gi = 0; gi < ADDR_W; gi++) begin : g_bit
    assign bit_ok[gi] = ~cfg_mask[gi] | (addr_lo[gi] == cfg_base[gi]);
  end

  assign addr_ok      = &bit_ok;
  assign status_valid = s0 ^ s1;
  assign is_read      = s0 & ~s1;
  assign dir_ok       = is_read ? cfg_rd_en : cfg_wr_en;
  assign hit          = ~m_io & status_valid & addr_ok & dir_ok;

endmodule

// File: rtl/chrdy_seq_ctrl.sv
module chrdy_seq_ctrl
  import chrdy_pkg::*;
#(
  parameter int DEADLINE_CYC = 3,
  parameter int MAX_STRETCH  = 64,
  parameter int CNT_W        = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_start,
  input  logic cyc_end,
  input  logic status_valid,
  input  logic hit,
  input  logic be_done,
  output logic stretch_q,
  output logic timeout_err
);

  localparam logic [CNT_W-1:0] DL_LAST = CNT_W'(DEADLINE_CYC - 1);
  localparam logic [CNT_W-1:0] MS_LAST = CNT_W'(MAX_STRETCH - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             err_q, err_set;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q + CNT_W'(1);
    cnt_en  = 1'b0;
    err_set = 1'b0;
    case (state_q)
      ST_IDLE, ST_HOLD: begin
        if (cyc_start) begin
          state_d = ST_DECIDE;
          cnt_d   = '0;
          cnt_en  = 1'b1;
        end else if (cyc_end) begin
          state_d = ST_IDLE;
        end
      end
      ST_DECIDE: begin
        if (cyc_end) begin
          state_d = ST_IDLE;
        end else if (status_valid) begin
          state_d = hit ? ST_STRETCH : ST_HOLD;
          cnt_d   = '0;
          cnt_en  = 1'b1;
        end else if (cnt_q == DL_LAST) begin
          state_d = ST_HOLD;
        end else begin
          cnt_en = 1'b1;
        end
      end
      ST_STRETCH: begin
        if (cyc_end) begin
          state_d = ST_IDLE;
        end else if (be_done) begin
          state_d = ST_HOLD;
        end else if (cnt_q == MS_LAST) begin
          state_d = ST_HOLD;
          err_set = 1'b1;
        end else begin
          cnt_en = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cnt_en)  cnt_q <= cnt_d;
      if (err_set) err_q <= 1'b1;
    end
  end

  assign stretch_q   = (state_q == ST_STRETCH);
  assign timeout_err = err_q;

endmodule

// File: rtl/chrdy_early_stretch.sv
module chrdy_early_stretch #(
  parameter int ADDR_W       = 8,
  parameter int DEADLINE_CYC = 3,
  parameter int MAX_STRETCH  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_start,
  input  logic              cyc_end,
  input  logic              m_io,
  input  logic              s0,
  input  logic              s1,
  input  logic [ADDR_W-1:0] addr_lo,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_mask,
  input  logic              cfg_rd_en,
  input  logic              cfg_wr_en,
  input  logic              be_done,
  output logic              chrdy_drive,
  output logic              timeout_err
);

  localparam int CNT_MAX = (DEADLINE_CYC > MAX_STRETCH) ? DEADLINE_CYC : MAX_STRETCH;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  logic       status_valid;
  logic       hit;
  logic       stretch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  chrdy_window_match #(
    .ADDR_W (ADDR_W)
  ) u_match (
    .m_io         (m_io),
    .s0           (s0),
    .s1           (s1),
    .addr_lo      (addr_lo),
    .cfg_base     (cfg_base),
    .cfg_mask     (cfg_mask),
    .cfg_rd_en    (cfg_rd_en),
    .cfg_wr_en    (cfg_wr_en),
    .status_valid (status_valid),
    .hit          (hit)
  );

  chrdy_seq_ctrl #(
    .DEADLINE_CYC (DEADLINE_CYC),
    .MAX_STRETCH  (MAX_STRETCH),
    .CNT_W        (CNT_W)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .cyc_start    (cyc_start),
    .cyc_end      (cyc_end),
    .status_valid (status_valid),
    .hit          (hit),
    .be_done      (be_done),
    .stretch_q    (stretch_q),
    .timeout_err  (timeout_err)
  );

  assign chrdy_drive = stretch_q & ~cyc_end;

endmodule

// File: rtl/chrdy_early_stretch_chk.sv
module chrdy_early_stretch_chk #(
  parameter int ADDR_W       = 8,
  parameter int DEADLINE_CYC = 3,
  parameter int MAX_STRETCH  = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cyc_start,
  input logic              cyc_end,
  input logic              m_io,
  input logic              s0,
  input logic              s1,
  input logic [ADDR_W-1:0] addr_lo,
  input logic [ADDR_W-1:0] cfg_base,
  input logic [ADDR_W-1:0] cfg_mask,
  input logic              cfg_rd_en,
  input logic              cfg_wr_en,
  input logic              be_done,
  input logic              chrdy_drive,
  input logic              timeout_err
);

  localparam int SW = $clog2(DEADLINE_CYC + 3);
  localparam int RW = $clog2(MAX_STRETCH + 2);
  localparam logic [SW-1:0] SINCE_SAT = SW'(DEADLINE_CYC + 2);
  localparam logic [SW-1:0] SINCE_MAX = SW'(DEADLINE_CYC + 1);
  localparam logic [RW-1:0] RUN_SAT   = RW'(MAX_STRETCH + 1);
  localparam logic [RW-1:0] RUN_LIM   = RW'(MAX_STRETCH);

  logic [SW-1:0] since_q;
  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= SINCE_SAT;
      run_q   <= '0;
    end else begin
      if (cyc_start)               since_q <= SW'(1);
      else if (since_q != SINCE_SAT) since_q <= since_q + SW'(1);
      if (!chrdy_drive)            run_q <= '0;
      else if (run_q != RUN_SAT)   run_q <= run_q + RW'(1);
    end
  end

  // R2
  io_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chrdy_drive) |-> $past(s0 != s1));

  // R3
  io_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chrdy_drive) |-> $past(!m_io));

  // R4
  in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chrdy_drive) |-> $past(((addr_lo ^ cfg_base) & cfg_mask) == '0));

  // R5
  dir_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chrdy_drive) |-> $past((s0 && !s1) ? cfg_rd_en : cfg_wr_en));

  // R6
  deadline_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chrdy_drive) |-> (since_q >= SW'(2) && since_q <= SINCE_MAX));

  // R7
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chrdy_drive && be_done) |=> !chrdy_drive);

  // R8
  end_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end |=> !chrdy_drive);

  // R9
  max_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chrdy_drive |-> (run_q < RUN_LIM));

  // R9
  err_on_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> $fell(chrdy_drive));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |=> timeout_err);

endmodule

bind chrdy_early_stretch chrdy_early_stretch_chk #(
  .ADDR_W       (ADDR_W),
  .DEADLINE_CYC (DEADLINE_CYC),
  .MAX_STRETCH  (MAX_STRETCH)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cyc_start   (cyc_start),
  .cyc_end     (cyc_end),
  .m_io        (m_io),
  .s0          (s0),
  .s1          (s1),
  .addr_lo     (addr_lo),
  .cfg_base    (cfg_base),
  .cfg_mask    (cfg_mask),
  .cfg_rd_en   (cfg_rd_en),
  .cfg_wr_en   (cfg_wr_en),
  .be_done     (be_done),
  .chrdy_drive (chrdy_drive),
  .timeout_err (timeout_err)
);

// File: tb/chrdy_early_stretch_bench.sv
module chrdy_early_stretch_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DL = 3;
  localparam int MS = 12;

  logic          clk;
  logic          rst_n;
  logic          cyc_start, cyc_end, m_io, s0, s1, be_done;
  logic [AW-1:0] addr_lo, cfg_base, cfg_mask;
  logic          cfg_rd_en, cfg_wr_en;
  logic          chrdy_drive, timeout_err;

  int checks;
  int fails;
  bit exp_err;

  chrdy_early_stretch #(
    .ADDR_W       (AW),
    .DEADLINE_CYC (DL),
    .MAX_STRETCH  (MS)
  ) u_chrdy_early_stretch (
    .clk         (clk),
    .rst_n       (rst_n),
    .cyc_start   (cyc_start),
    .cyc_end     (cyc_end),
    .m_io        (m_io),
    .s0          (s0),
    .s1          (s1),
    .addr_lo     (addr_lo),
    .cfg_base    (cfg_base),
    .cfg_mask    (cfg_mask),
    .cfg_rd_en   (cfg_rd_en),
    .cfg_wr_en   (cfg_wr_en),
    .be_done     (be_done),
    .chrdy_drive (chrdy_drive),
    .timeout_err (timeout_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    cyc_start = 1'b0; cyc_end = 1'b0; be_done = 1'b0;
    m_io = 1'b1; s0 = 1'b1; s1 = 1'b1; addr_lo = '0;
  endtask

  task automatic do_reset();
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();
    exp_err = 1'b0;
  endtask

  // Expected behaviour: typ 0 = read, 1 = write, 2 = no valid status.
  function automatic bit exp_match(input bit mio, input int typ, input logic [AW-1:0] a,
                                   input int v, input int e);
    bit dir;
    dir = (typ == 0) ? cfg_rd_en : cfg_wr_en;
    return !mio && (typ != 2) && (v <= DL) && (v < e) &&
           (((a ^ cfg_base) & cfg_mask) == '0) && dir;
  endfunction

  task automatic run_cyc(input string tag, input bit mio, input int typ,
                         input logic [AW-1:0] a, input int v, input int d,
                         input int e, input bit flip);
    int first_hi, hi_cnt, last, exp_first, exp_cnt;
    bit m, to;
    m = exp_match(mio, typ, a, v, e);
    cyc_start = 1'b1; m_io = mio; s0 = 1'b1; s1 = 1'b1; addr_lo = a;
    be_done = 1'b0; cyc_end = 1'b0;
    step();
    cyc_start = 1'b0;
    first_hi = 0; hi_cnt = 0;
    for (int i = 1; i <= e; i++) begin
      if (chrdy_drive) begin
        hi_cnt++;
        if (first_hi == 0) first_hi = i;
      end
      if (i >= v) begin
        s0 = (typ == 0) || (typ == 2);
        s1 = (typ == 1) || (typ == 2);
      end
      if (flip && i > v) addr_lo = cfg_base;
      be_done = (i == d);
      cyc_end = (i == e);
      if (i == e) begin
        #1;
        chk({tag, " R8 drive during cyc_end"}, int'(chrdy_drive), 0);
      end
      step();
    end
    cyc_end = 1'b0; be_done = 1'b0; s0 = 1'b1; s1 = 1'b1;
    chk({tag, " R8 drive after end"}, int'(chrdy_drive), 0);
    exp_first = 0; exp_cnt = 0; to = 1'b0;
    if (m) begin
      last = v + MS;
      if (d > v && d < last) last = d;
      if (e < last) last = e;
      exp_first = v + 1;
      exp_cnt   = last - v;
      to = (e > v + MS) && !(d > v && d <= v + MS);
    end
    exp_err = exp_err | to;
    chk({tag, " first high cycle"}, first_hi, exp_first);
    chk({tag, " high cycle count"}, hi_cnt, exp_cnt);
    chk({tag, " R9 timeout_err"}, int'(timeout_err), int'(exp_err));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    checks = 0; fails = 0;
    cfg_base = 8'h40; cfg_mask = 8'hF0; cfg_rd_en = 1'b1; cfg_wr_en = 1'b1;
    do_reset();
    chk("R1 reset drive", int'(chrdy_drive), 0);
    chk("R1 reset err", int'(timeout_err), 0);

    run_cyc("R2 R7 io read match done", 1'b0, 0, 8'h42, 2, 6, 10, 1'b0);
    run_cyc("R2 io write match late status", 1'b0, 1, 8'h47, 3, 7, 9, 1'b0);
    run_cyc("R3 memory never", 1'b1, 0, 8'h42, 1, 5, 8, 1'b0);
    run_cyc("R4 outside window", 1'b0, 0, 8'h50, 1, 5, 8, 1'b0);
    run_cyc("R4 masked low bits", 1'b0, 0, 8'h4F, 1, 4, 8, 1'b0);
    run_cyc("R2 no valid status", 1'b0, 2, 8'h41, 1, 4, 8, 1'b0);
    cfg_wr_en = 1'b0;
    run_cyc("R5 write disabled", 1'b0, 1, 8'h41, 1, 4, 8, 1'b0);
    run_cyc("R5 read still enabled", 1'b0, 0, 8'h41, 1, 4, 8, 1'b0);
    cfg_wr_en = 1'b1; cfg_rd_en = 1'b0;
    run_cyc("R5 read disabled", 1'b0, 0, 8'h41, 1, 4, 8, 1'b0);
    cfg_rd_en = 1'b1;
    run_cyc("R6 status after deadline", 1'b0, 0, 8'h41, DL + 1, 7, 10, 1'b0);
    run_cyc("R6 status at deadline", 1'b0, 0, 8'h41, DL, 7, 10, 1'b0);
    run_cyc("R7 early done ignored", 1'b0, 0, 8'h41, 2, 1, 6, 1'b0);
    run_cyc("R8 end mid stretch", 1'b0, 0, 8'h43, 2, 0, 5, 1'b0);
    run_cyc("R10 late addr change", 1'b0, 0, 8'h90, 1, 0, 6, 1'b1);
    run_cyc("R9 timeout", 1'b0, 0, 8'h44, 1, 0, MS + 4, 1'b0);
    run_cyc("R9 err stays", 1'b0, 1, 8'h45, 2, 5, 8, 1'b0);
    do_reset();
    chk("R1 reset clears err", int'(timeout_err), 0);

    void'($urandom(32'd20240611));
    for (int n = 0; n < 80; n++) begin
      bit mio, fl;
      int typ, v, d, e;
      logic [AW-1:0] a;
      if (n % 20 == 0) begin
        cfg_base  = $urandom;
        cfg_mask  = ($urandom % 2 == 0) ? 8'hF8 : 8'hFF;
        cfg_rd_en = ($urandom % 4) != 0;
        cfg_wr_en = ($urandom % 4) != 0;
      end
      mio = ($urandom % 4) == 0;
      typ = ($urandom % 5 == 0) ? 2 : int'($urandom % 2);
      a   = ($urandom % 3 == 0) ? AW'($urandom) : (cfg_base ^ (AW'($urandom) & ~cfg_mask));
      v   = 1 + int'($urandom % (DL + 1));
      d   = int'($urandom % (MS + 6));
      e   = v + 1 + int'($urandom % (MS + 4));
      fl  = ($urandom % 4) == 0;
      run_cyc("R2 R4 R7 random", mio, typ, a, v, d, e, fl);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule